// File: doc/BRIEF.md
# Virtual Wire Reset Handshake Responder

This block sits on the slave side of a serial virtual-wire link and answers the master's system-event handshakes in hardware. The incoming wires arrive already decoded as two 32-bit groups. The block drives the matching outgoing groups, so no processor has to step in. A warning that the host domain is about to reset is mirrored onto a host acknowledge. A warning that the out-of-band domain is about to reset is mirrored onto its own acknowledge in the same way, but independently. A rising suspend warning latches a suspend acknowledge.

A hardware link-reset event pulses an 8-bit soft-reset field low for exactly one cycle. When the field returns to all ones, the boot-load-done and boot-load-status wires come back high by themselves. The boot-load-status wire being high tells the master that the local boot image loaded intact. A local boot-complete strobe plays the part of initialisation. It raises both boot wires if status is still clear, and it raises the suspend acknowledge if the suspend warning is already high.

Incoming wires are registered once on the system clock. Edges are found against a second, one-cycle-delayed copy of the wires. As a result, an acknowledge reacts on the second rising clock edge after its warning changes.

Top module: `vw_reset_responder`

## Requirements
- R1: The host acknowledge (outgoing group 0, bit 27) equals the host reset warning level (incoming group 0, bit 8). After the warning changes, the acknowledge keeps its old value through the first rising edge and takes the new level at the second rising edge.
- R2: The out-of-band acknowledge (outgoing group 0, bit 16) mirrors the out-of-band reset warning (incoming group 0, bit 6) with the same two-edge timing as R1, and it does not depend on the host pair.
- R3: A rising edge on the suspend warning (incoming group 1, bit 0) sets the suspend acknowledge (outgoing group 1, bit 20) at the second rising edge after the warning rises. A falling warning leaves the acknowledge set, and only the reset input clears it.
- R4: When the link-reset event is sampled high at a rising edge, the soft-reset field reads 8'h00 and both boot wires (outgoing group 0, bits 20 and 23) read 0 for one cycle. At the next edge the field reads 8'hFF and both boot wires read 1.
- R5: A link-reset event that is still high during the zero cycle of the soft-reset field is ignored. The field goes back to 8'hFF and does not pulse again.
- R6: A boot-complete strobe sampled at a rising edge sets both boot wires at that edge when boot-load-status is clear. When status is already set, the strobe changes nothing.
- R7: A boot-complete strobe sets the suspend acknowledge at that edge if the registered suspend warning is high. A warning that is already high when reset is released produces no edge and does not set the acknowledge by itself.
- R8: When the link-reset event and the boot-complete strobe are sampled at the same edge, the link reset wins: both boot wires read 0 during the zero cycle and 1 after it.
- R9: Outgoing bits other than group 0 bits 16, 20, 23 and 27 and group 1 bit 20 always read 0. Incoming bits other than group 0 bits 6 and 8 and group 1 bit 0 have no effect on any output. This includes the platform-reset wire at group 0 bit 5.
- R10: While reset is held with all incoming wires low, both outgoing groups read 0 and the soft-reset field reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_rst_evt | input | 1 | Hardware link-reset event, sampled each rising edge |
| boot_cmplt | input | 1 | Local boot-complete strobe, used as initialisation |
| vw_in_g0 | input | 32 | Decoded incoming system-event wires, group 0 |
| vw_in_g1 | input | 32 | Decoded incoming system-event wires, group 1 |
| vw_out_g0 | output | 32 | Outgoing system-event wires, group 0 |
| vw_out_g1 | output | 32 | Outgoing system-event wires, group 1 |
| soft_rst | output | 8 | Soft-reset field, all ones when idle |

## Verification
Two functions can fall in the same cycle. The link-reset event and the boot-complete strobe both write the boot wires, and a warning change can land in the same cycle as the soft-reset pulse. The bench drives the event, the strobe and a rising host warning on one falling edge, with the suspend warning already held high since reset. It then checks that the boot wires stay low during the zero cycle and come up with the field. The host acknowledge must keep its own two-edge timing, and the suspend acknowledge must still be set by the strobe.

// File: rtl/vw_resp_pkg.sv
// Shared types for the virtual-wire reset handshake responder.
// Assumes: nothing beyond IEEE 1800-2017.
package vw_resp_pkg;

    // Phases of the link-reset sequence.
    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_PULSE = 1'b1
    } seq_state_e;

    // Number of warning/acknowledge pairs that follow the level-mirroring rule.
    localparam int NUM_MIRROR = 2;

endpackage

// File: rtl/vw_wire_sampler.sv
// Registers a wire vector on the system clock and keeps a copy delayed by one
// more cycle, so that consumers can find edges by comparing the two.
// Assumes: the inputs are already synchronous to clk. The registers track
// their input even while reset is held. This way a wire that sits high across
// reset release shows no edge.
module vw_wire_sampler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);

    // Two-stage capture: current sample and previous sample.
    always_ff @(posedge clk) begin
        cur_o  <= d_i;
        prev_o <= cur_o;
    end

endmodule

// File: rtl/vw_ack_mirror.sv
// Drives one acknowledge wire so that it follows the level of its warning
// wire. It updates only in a cycle where the sampled warning differs from its
// delayed copy.
// Assumes: warn_cur_i / warn_prev_i come from a vw_wire_sampler.
module vw_ack_mirror (
    input  logic clk,
    input  logic rst_n,
    input  logic warn_cur_i,
    input  logic warn_prev_i,
    output logic ack_o
);

    // Copy the warning level into the acknowledge on every observed change.
    // During reset, load the sample so that ack tracks the delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o <= warn_cur_i;
        end else if (warn_cur_i != warn_prev_i) begin
            ack_o <= warn_cur_i;
        end
    end

    // R1
    ack_matches_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_cur_i == warn_prev_i) |-> (ack_o == warn_cur_i));

    // R2
    ack_moves_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ack_o) |-> $past(warn_cur_i != warn_prev_i));

endmodule

// File: rtl/vw_sus_ack.sv
// Latches the suspend acknowledge on a rising suspend warning, or on the
// initialisation strobe while the warning is high. Only reset clears it.
// Assumes: warn_cur_i / warn_prev_i come from a vw_wire_sampler.
module vw_sus_ack (
    input  logic clk,
    input  logic rst_n,
    input  logic warn_cur_i,
    input  logic warn_prev_i,
    input  logic init_i,
    output logic ack_o
);

    logic warn_rise;

    // Edge detect against the delayed copy.
    always_comb warn_rise = warn_cur_i & ~warn_prev_i;

    // Sticky set of the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o <= 1'b0;
        end else if (warn_rise || (init_i && warn_cur_i)) begin
            ack_o <= 1'b1;
        end
    end

    // R3
    sus_ack_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> ack_o);

    // R7
    sus_ack_needs_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(warn_cur_i));

endmodule

// File: rtl/vw_link_rst_seq.sv
// Sequences the response to a hardware link-reset event. The soft-reset field
// is zero for one cycle and the boot wires are cleared. The field then returns
// to all ones and both boot wires are re-asserted. It also handles the
// initialisation strobe that raises the boot wires once.
// Assumes: link_evt_i and boot_init_i are synchronous to clk.
module vw_link_rst_seq
    import vw_resp_pkg::*;
#(
    parameter int SRST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_evt_i,
    input  logic              boot_init_i,
    output logic [SRST_W-1:0] soft_rst_o,
    output logic              boot_done_o,
    output logic              boot_stat_o
);

    localparam logic [SRST_W-1:0] SRST_IDLE = {SRST_W{1'b1}};
    localparam logic [SRST_W-1:0] SRST_HIT  = {SRST_W{1'b0}};

    seq_state_e state_q;

    // Sequence state, soft-reset field and boot wires; a link event outranks the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SEQ_IDLE;
            soft_rst_o  <= SRST_IDLE;
            boot_done_o <= 1'b0;
            boot_stat_o <= 1'b0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (link_evt_i) begin
                        state_q     <= SEQ_PULSE;
                        soft_rst_o  <= SRST_HIT;
                        boot_done_o <= 1'b0;
                        boot_stat_o <= 1'b0;
                    end else if (boot_init_i && !boot_stat_o) begin
                        boot_done_o <= 1'b1;
                        boot_stat_o <= 1'b1;
                    end
                end
                SEQ_PULSE: begin
                    state_q     <= SEQ_IDLE;
                    soft_rst_o  <= SRST_IDLE;
                    boot_done_o <= 1'b1;
                    boot_stat_o <= 1'b1;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // R4
    soft_rst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_o == SRST_HIT) |=> (soft_rst_o == SRST_IDLE));

    // R4
    soft_rst_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_o == SRST_HIT) || (soft_rst_o == SRST_IDLE));

    // R4
    boot_back_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_o == SRST_HIT) |=> (boot_done_o && boot_stat_o));

    // R8
    boot_low_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_o == SRST_HIT) |-> (!boot_done_o && !boot_stat_o));

    // R5
    no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_PULSE) |=> (state_q == SEQ_IDLE));

    // R6
    boot_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done_o == boot_stat_o);

endmodule

// File: rtl/vw_reset_responder.sv
// Top of the virtual-wire reset handshake responder. It samples both incoming
// wire groups, mirrors the host and out-of-band reset warnings onto their
// acknowledges, and latches the suspend acknowledge. It also runs the
// link-reset sequence and assembles the outgoing groups from the owned bits
// only.
// Assumes: wire groups are decoded and synchronous to clk; bit positions are
// fixed by the link's wire map and must stay unique within a group.
module vw_reset_responder
    import vw_resp_pkg::*;
#(
    parameter int G0_W          = 32,
    parameter int G1_W          = 32,
    parameter int SRST_W        = 8,
    parameter int HOST_WARN_BIT = 8,
    parameter int HOST_ACK_BIT  = 27,
    parameter int OOB_WARN_BIT  = 6,
    parameter int OOB_ACK_BIT   = 16,
    parameter int BOOT_DONE_BIT = 20,
    parameter int BOOT_STAT_BIT = 23,
    parameter int SUS_WARN_BIT  = 0,
    parameter int SUS_ACK_BIT   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_rst_evt,
    input  logic              boot_cmplt,
    input  logic [G0_W-1:0]   vw_in_g0,
    input  logic [G1_W-1:0]   vw_in_g1,
    output logic [G0_W-1:0]   vw_out_g0,
    output logic [G1_W-1:0]   vw_out_g1,
    output logic [SRST_W-1:0] soft_rst
);

    localparam int MIR_WARN [NUM_MIRROR] = '{HOST_WARN_BIT, OOB_WARN_BIT};
    localparam int MIR_ACK  [NUM_MIRROR] = '{HOST_ACK_BIT,  OOB_ACK_BIT};
    localparam logic [G0_W-1:0] G0_ONE   = {{(G0_W-1){1'b0}}, 1'b1};
    localparam logic [G1_W-1:0] G1_ONE   = {{(G1_W-1){1'b0}}, 1'b1};
    localparam logic [G0_W-1:0] G0_OWNED = (G0_ONE << HOST_ACK_BIT) | (G0_ONE << OOB_ACK_BIT)
                                         | (G0_ONE << BOOT_DONE_BIT) | (G0_ONE << BOOT_STAT_BIT);
    localparam logic [G1_W-1:0] G1_OWNED = G1_ONE << SUS_ACK_BIT;

    logic [G0_W-1:0]       g0_cur, g0_prev;
    logic [G1_W-1:0]       g1_cur, g1_prev;
    logic [NUM_MIRROR-1:0] mir_ack;
    logic                  sus_ack;
    logic                  boot_done;
    logic                  boot_stat;

    vw_wire_sampler #(.W(G0_W)) u_samp_g0 (
        .clk    (clk),
        .d_i    (vw_in_g0),
        .cur_o  (g0_cur),
        .prev_o (g0_prev)
    );

    vw_wire_sampler #(.W(G1_W)) u_samp_g1 (
        .clk    (clk),
        .d_i    (vw_in_g1),
        .cur_o  (g1_cur),
        .prev_o (g1_prev)
    );

    // One level mirror per warning/acknowledge pair.
    for (genvar i = 0; i < NUM_MIRROR; i++) begin : g_mirror
        vw_ack_mirror u_mirror (
            .clk         (clk),
            .rst_n       (rst_n),
            .warn_cur_i  (g0_cur[MIR_WARN[i]]),
            .warn_prev_i (g0_prev[MIR_WARN[i]]),
            .ack_o       (mir_ack[i])
        );
    end

    vw_sus_ack u_sus (
        .clk         (clk),
        .rst_n       (rst_n),
        .warn_cur_i  (g1_cur[SUS_WARN_BIT]),
        .warn_prev_i (g1_prev[SUS_WARN_BIT]),
        .init_i      (boot_cmplt),
        .ack_o       (sus_ack)
    );

    vw_link_rst_seq #(.SRST_W(SRST_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_evt_i  (link_rst_evt),
        .boot_init_i (boot_cmplt),
        .soft_rst_o  (soft_rst),
        .boot_done_o (boot_done),
        .boot_stat_o (boot_stat)
    );

    // Place the owned bits into the outgoing groups; all other bits stay zero.
    always_comb begin
        vw_out_g0 = '0;
        vw_out_g1 = '0;
        for (int i = 0; i < NUM_MIRROR; i++) begin
            vw_out_g0[MIR_ACK[i]] = mir_ack[i];
        end
        vw_out_g0[BOOT_DONE_BIT] = boot_done;
        vw_out_g0[BOOT_STAT_BIT] = boot_stat;
        vw_out_g1[SUS_ACK_BIT]   = sus_ack;
    end

    // R9
    unowned_g0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vw_out_g0 & ~G0_OWNED) == '0);

    // R9
    unowned_g1_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vw_out_g1 & ~G1_OWNED) == '0);

    // R1
    host_ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(g0_cur[HOST_WARN_BIT]) && $stable(g0_prev[HOST_WARN_BIT]))
        |=> $stable(vw_out_g0[HOST_ACK_BIT]));

endmodule

// File: tb/vw_reset_responder_tb.sv
module vw_reset_responder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HW = 8, HA = 27, OW = 6, OA = 16, BD = 20, BS = 23, SW = 0, SA = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_rst_evt = 1'b0;
    logic        boot_cmplt = 1'b0;
    logic [31:0] vw_in_g0 = '0;
    logic [31:0] vw_in_g1 = '0;
    logic [31:0] vw_out_g0, vw_out_g1;
    logic [7:0]  soft_rst;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    vw_reset_responder u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .link_rst_evt (link_rst_evt),
        .boot_cmplt   (boot_cmplt),
        .vw_in_g0     (vw_in_g0),
        .vw_in_g1     (vw_in_g1),
        .vw_out_g0    (vw_out_g0),
        .vw_out_g1    (vw_out_g1),
        .soft_rst     (soft_rst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_g0(input bit h, input bit o, input bit b);
        return (32'(h) << HA) | (32'(o) << OA) | (32'(b) << BD) | (32'(b) << BS);
    endfunction

    // Advance n rising edges and stop on the following falling edge.
    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R10 reset state
        chk("R10 g0", vw_out_g0, 32'h0);
        chk("R10 g1", vw_out_g1, 32'h0);
        chk("R10 soft_rst", {24'h0, soft_rst}, 32'hFF);

        // R1 R2: every transition of the host/oob warning pair
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                vw_in_g0[HW] = a[0]; vw_in_g0[OW] = a[1];
                step(3);
                vw_in_g0[HW] = b[0]; vw_in_g0[OW] = b[1];
                step(1);
                chk("R1 R2 first edge holds", vw_out_g0, exp_g0(a[0], a[1], 1'b0));
                step(1);
                chk("R1 R2 second edge mirrors", vw_out_g0, exp_g0(b[0], b[1], 1'b0));
            end
        end
        vw_in_g0 = '0;
        step(3);

        // R3 suspend acknowledge
        vw_in_g1[SW] = 1'b1;
        step(1);
        chk("R3 not yet", vw_out_g1, 32'h0);
        step(1);
        chk("R3 set", vw_out_g1, 32'h1 << SA);
        vw_in_g1[SW] = 1'b0;
        step(3);
        chk("R3 sticky", vw_out_g1, 32'h1 << SA);

        // R9 walking one over unused incoming bits
        for (int g = 0; g < 2; g++) begin
            for (int i = 0; i < 32; i++) begin
                if ((g == 0 && (i == HW || i == OW)) || (g == 1 && i == SW)) continue;
                if (g == 0) vw_in_g0 = 32'h1 << i; else vw_in_g1 = 32'h1 << i;
                step(3);
                chk($sformatf("R9 g0 bit%0d grp%0d", i, g), vw_out_g0, exp_g0(1'b0, 1'b0, 1'b0));
                chk($sformatf("R9 g1 bit%0d grp%0d", i, g), vw_out_g1, 32'h1 << SA);
                vw_in_g0 = '0; vw_in_g1 = '0;
            end
        end
        step(3);

        // R6 strobe raises boot wires while status clear
        boot_cmplt = 1'b1;
        step(1);
        boot_cmplt = 1'b0;
        chk("R6 boot set", vw_out_g0, exp_g0(1'b0, 1'b0, 1'b1));
        boot_cmplt = 1'b1;
        step(1);
        boot_cmplt = 1'b0;
        chk("R6 already set unchanged", vw_out_g0, exp_g0(1'b0, 1'b0, 1'b1));

        // R4 R5 link reset, event held through the pulse cycle
        link_rst_evt = 1'b1;
        step(1);
        chk("R4 soft_rst zero", {24'h0, soft_rst}, 32'h0);
        chk("R4 boot low in pulse", vw_out_g0, exp_g0(1'b0, 1'b0, 1'b0));
        step(1);
        link_rst_evt = 1'b0;
        chk("R4 soft_rst restored", {24'h0, soft_rst}, 32'hFF);
        chk("R4 boot reasserted", vw_out_g0, exp_g0(1'b0, 1'b0, 1'b1));
        step(1);
        chk("R5 no second pulse", {24'h0, soft_rst}, 32'hFF);
        step(1);
        chk("R5 still idle", {24'h0, soft_rst}, 32'hFF);

        // R7 R8: suspend warning high across reset; event, strobe and host warn together
        vw_in_g1[SW] = 1'b1;
        do_reset();
        step(3);
        chk("R7 no edge no ack", vw_out_g1, 32'h0);
        link_rst_evt = 1'b1; boot_cmplt = 1'b1; vw_in_g0[HW] = 1'b1;
        step(1);
        link_rst_evt = 1'b0; boot_cmplt = 1'b0;
        chk("R8 soft_rst zero", {24'h0, soft_rst}, 32'h0);
        chk("R8 link wins boot low, R1 host holds", vw_out_g0, exp_g0(1'b0, 1'b0, 1'b0));
        chk("R7 strobe sets suspend ack", vw_out_g1, 32'h1 << SA);
        step(1);
        chk("R8 soft_rst restored", {24'h0, soft_rst}, 32'hFF);
        chk("R8 boot up, R1 host ack", vw_out_g0, exp_g0(1'b1, 1'b0, 1'b1));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule